// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 18-bit ports, called A and B, with one independent storage path in each direction. Each path's storage element works in one of three ways. While its latch enable is high it passes the input straight through. While the latch enable is low it keeps its contents unchanged. While the latch enable is low it also loads new data whenever its own control clock goes from low to high. A drive flag on each port marks whether that port's output is active, which keeps the block free of internal tri-state logic. The top level or the board turns the flag and the data into real pad drivers.

The control clocks are treated as data. They are sampled on the system clock `clk`, and a rise is a sample of 1 that follows a sample of 0. Each input bit has its own "driven" qualifier. When the qualifier is low and the bus-hold option is on, the bit reads as the last value it had while driven. When the option is off, an undriven bit reads as 0.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all stored data and all bus-hold values are 0. An enabled output therefore shows 0 when its latch enable is low. The control-clock history resets to 1, so a control clock that is already high when reset ends does not count as a rise.
- R2: When a direction's latch enable is 1, its output data equals that direction's effective input in the same cycle. The effective input is the input bus after bus hold is applied.
- R3: When the latch enable is 0 and there is no control-clock rise, the output keeps its value, whatever the input does.
- R4: When the latch enable is 0 and a control-clock rise is sampled on edge N of `clk`, the effective input sampled on that edge becomes the output from edge N onward.
- R5: When the latch enable falls, the output keeps the effective input from the last cycle in which the enable was 1. A control-clock rise while the enable is 1 has no effect beyond the transparent pass.
- R6: The A-to-B enable `ab_oe` is active high. `b_oe` equals `ab_oe`. While `ab_oe` is 0, `b_out` is all zeros.
- R7: The B-to-A enable `ba_oe_n` is active low. `a_oe` equals the inverse of `ba_oe_n`. While `ba_oe_n` is 1, `a_out` is all zeros.
- R8: The two directions are independent. The controls and data of one direction never change the output of the other, even when both are active in the same cycle.
- R9: With `BUS_HOLD`=1, an input bit whose driven qualifier is 0 reads as the value it had on the last clock edge on which its qualifier was 1. It reads as 0 if it has never been driven since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | Data arriving at port A |
| a_drv | input | 18 | Per-bit "driven" qualifier for `a_in` |
| a_out | output | 18 | Data driven onto port A (zero when off) |
| a_oe | output | 1 | Port A drive flag |
| b_in | input | 18 | Data arriving at port B |
| b_drv | input | 18 | Per-bit "driven" qualifier for `b_in` |
| b_out | output | 18 | Data driven onto port B (zero when off) |
| b_oe | output | 1 | Port B drive flag |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B control clock (sampled) |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A control clock (sampled) |

## Verification
The hardest case to reach from the ports is a latch enable that falls in the same cycle as a control-clock rise, or just after one, while some input bits are undriven. In that case the stored value depends on three separate histories: the enable, the clock sample and the per-bit hold register. The stimulus has a dedicated phase that toggles the latch enable while the control clock rises and some input bits are undriven. A final phase randomizes every control and qualifier of both directions together. A behavioural model tracks all three histories, and each cycle's outputs are compared against it.

// File: rtl/reg_bus_xcvr_pkg.sv
package reg_bus_xcvr_pkg;

    // Operating state of one storage path, decoded every cycle
    typedef enum logic [1:0] {
        MODE_KEEP    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } store_mode_e;

    localparam int unsigned XCVR_WIDTH = 18;

endpackage

// File: rtl/bus_hold_in.sv
module bus_hold_in #(
    parameter int unsigned W    = 18,
    parameter bit          HOLD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] drv,
    output logic [W-1:0] eff
);

    typedef struct packed {
        logic [W-1:0] keep;
    } hold_state_t;

    hold_state_t st_d, st_q;

    generate
        if (HOLD) begin : g_hold
            always_comb begin
                st_d = st_q;
                for (int i = 0; i < int'(W); i++) begin
                    if (drv[i]) st_d.keep[i] = pin[i];
                end
            end
            for (genvar i = 0; i < int'(W); i++) begin : g_bit
                assign eff[i] = drv[i] ? pin[i] : st_q.keep[i];
            end
        end else begin : g_nohold
            always_comb begin
                st_d = '0;
            end
            assign eff = pin & drv;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    hold_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD && drv == '0) |=> (st_q == $past(st_q)));

    // R9
    hold_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD && drv == '1) |=> (st_q.keep == $past(pin)));

endmodule

// File: rtl/store_path.sv
module store_path
    import reg_bus_xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         cclk,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         cclk_prev;
    } path_state_t;

    path_state_t st_d, st_q;
    store_mode_e mode;
    logic        rise;

    assign rise = cclk & ~st_q.cclk_prev;

    always_comb begin
        if (le)        mode = MODE_PASS;
        else if (rise) mode = MODE_CAPTURE;
        else           mode = MODE_KEEP;
    end

    always_comb begin
        st_d           = st_q;
        st_d.cclk_prev = cclk;
        unique case (mode)
            MODE_PASS:    st_d.data = din;
            MODE_CAPTURE: st_d.data = din;
            default:      st_d.data = st_q.data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data      <= '0;
            st_q.cclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = (mode == MODE_PASS) ? din : st_q.data;

    // R2
    pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> (dout == din));

    // R3
    keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !(cclk && !st_q.cclk_prev)) |=> (st_q.data == $past(st_q.data)));

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && cclk && !$past(cclk)) |=> (st_q.data == $past(din)));

    // R5
    close_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le) |-> (dout == $past(din)));

endmodule

// File: rtl/port_gate.sv
module port_gate #(
    parameter int unsigned W          = 18,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         oe_pin,
    output logic [W-1:0] dout,
    output logic         en
);

    generate
        if (ACTIVE_LOW) begin : g_low
            assign en = ~oe_pin;
        end else begin : g_high
            assign en = oe_pin;
        end
    endgenerate

    assign dout = en ? din : '0;

    // R6 R7
    gate_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_pin == ACTIVE_LOW) |-> (dout == '0 && !en));

    // R6 R7
    gate_on_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_pin != ACTIVE_LOW) |-> (dout == din && en));

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
    import reg_bus_xcvr_pkg::*;
#(
    parameter int unsigned W        = XCVR_WIDTH,
    parameter bit          BUS_HOLD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk
);

    logic [W-1:0] a_eff, b_eff;
    logic [W-1:0] ab_data, ba_data;

    bus_hold_in #(.W(W), .HOLD(BUS_HOLD)) u_hold_a (
        .clk(clk), .rst_n(rst_n), .pin(a_in), .drv(a_drv), .eff(a_eff)
    );

    bus_hold_in #(.W(W), .HOLD(BUS_HOLD)) u_hold_b (
        .clk(clk), .rst_n(rst_n), .pin(b_in), .drv(b_drv), .eff(b_eff)
    );

    store_path #(.W(W)) u_path_ab (
        .clk(clk), .rst_n(rst_n), .din(a_eff), .le(ab_le), .cclk(ab_clk),
        .dout(ab_data)
    );

    store_path #(.W(W)) u_path_ba (
        .clk(clk), .rst_n(rst_n), .din(b_eff), .le(ba_le), .cclk(ba_clk),
        .dout(ba_data)
    );

    port_gate #(.W(W), .ACTIVE_LOW(1'b0)) u_gate_b (
        .clk(clk), .rst_n(rst_n), .din(ab_data), .oe_pin(ab_oe),
        .dout(b_out), .en(b_oe)
    );

    port_gate #(.W(W), .ACTIVE_LOW(1'b1)) u_gate_a (
        .clk(clk), .rst_n(rst_n), .din(ba_data), .oe_pin(ba_oe_n),
        .dout(a_out), .en(a_oe)
    );

    // R8
    ab_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_clk && $stable(ab_oe) && !$rose(ab_le)) |=> $stable(b_out) || ab_le || $changed(ab_oe) || ab_clk);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (!rst_n && !ab_le && ab_oe) |=> (!rst_n || ab_le || ab_clk || b_out == '0));

endmodule

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, a_drv, b_in, b_drv;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_oe, ab_le, ab_clk, ba_oe_n, ba_le, ba_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    logic [W-1:0] m_hold_a, m_hold_b, m_st_ab, m_st_ba;
    logic         m_prev_ab, m_prev_ba;

    always #5 clk = ~clk;

    reg_bus_xcvr #(.W(W), .BUS_HOLD(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk)
    );

    function automatic logic [W-1:0] eff(input logic [W-1:0] v,
                                         input logic [W-1:0] d,
                                         input logic [W-1:0] h);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = d[i] ? v[i] : h[i];
        return r;
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_now(input string tag);
        logic [W-1:0] ea, eb, xb, xa;
        ea = eff(a_in, a_drv, m_hold_a);
        eb = eff(b_in, b_drv, m_hold_b);
        xb = ab_le ? ea : m_st_ab;
        xa = ba_le ? eb : m_st_ba;
        if (!ab_oe)  xb = '0;
        if (ba_oe_n) xa = '0;
        cmp(tag, "b_out", b_out, xb);
        cmp(tag, "a_out", a_out, xa);
        cmp(tag, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, ab_oe});
        cmp(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~ba_oe_n});
    endtask

    task automatic model_edge();
        logic [W-1:0] ea, eb;
        if (!rst_n) begin
            m_hold_a = '0; m_hold_b = '0; m_st_ab = '0; m_st_ba = '0;
            m_prev_ab = 1'b1; m_prev_ba = 1'b1;
            return;
        end
        ea = eff(a_in, a_drv, m_hold_a);
        eb = eff(b_in, b_drv, m_hold_b);
        if (ab_le || (ab_clk && !m_prev_ab)) m_st_ab = ea;
        if (ba_le || (ba_clk && !m_prev_ba)) m_st_ba = eb;
        m_prev_ab = ab_clk;
        m_prev_ba = ba_clk;
        m_hold_a = ea;
        m_hold_b = eb;
    endtask

    // one cycle: inputs already set after a negedge; check, then advance
    task automatic cycle(input string tag);
        #1;
        check_now(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a_in = '1; b_in = '1; a_drv = '1; b_drv = '1;
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        ab_le = 1'b0; ba_le = 1'b0; ab_clk = 1'b1; ba_clk = 1'b1;
        m_hold_a = '0; m_hold_b = '0; m_st_ab = '0; m_st_ba = '0;
        m_prev_ab = 1'b1; m_prev_ba = 1'b1;
        @(negedge clk);
        // R1: reset state, outputs zero; clock held high across reset release
        for (int k = 0; k < 3; k++) cycle("R1");
        rst_n = 1'b1;
        cycle("R1");
        cycle("R1");

        // R2 transparent pass
        ab_le = 1'b1; ba_le = 1'b1;
        for (int k = 0; k < 20; k++) begin
            a_in = rnd(); b_in = rnd(); cycle("R2");
        end

        // R5 enable falls: last transparent value kept
        ab_le = 1'b0; ba_le = 1'b0;
        ab_clk = 1'b0; ba_clk = 1'b0;
        for (int k = 0; k < 10; k++) begin
            a_in = rnd(); b_in = rnd(); cycle("R5");
        end

        // R3 hold with clock steady low then steady high
        for (int k = 0; k < 20; k++) begin
            if (k == 10) begin ab_clk = 1'b1; ba_clk = 1'b1; end
            a_in = rnd(); b_in = rnd(); cycle("R3");
        end

        // R4 clocked capture, toggling control clocks
        for (int k = 0; k < 40; k++) begin
            ab_clk = ~ab_clk; ba_clk = (k % 3 == 0) ? ~ba_clk : ba_clk;
            a_in = rnd(); b_in = rnd(); cycle("R4");
        end

        // R5 rise while enable high, then enable toggles, partial drive
        for (int k = 0; k < 60; k++) begin
            ab_le = (k % 4) < 2; ba_le = (k % 5) < 2;
            ab_clk = k[0]; ba_clk = k[1];
            a_drv = rnd(); b_drv = rnd();
            a_in = rnd(); b_in = rnd(); cycle("R5");
        end
        a_drv = '1; b_drv = '1;

        // R6 R7 output enables
        for (int k = 0; k < 30; k++) begin
            ab_oe = k[0]; ba_oe_n = k[1]; ab_le = k[2]; ba_le = ~k[2];
            a_in = rnd(); b_in = rnd(); cycle(k[0] ? "R7" : "R6");
        end
        ab_oe = 1'b1; ba_oe_n = 1'b0;

        // R9 bus hold: drive, then release bits under transparency
        ab_le = 1'b1; ba_le = 1'b1;
        for (int k = 0; k < 40; k++) begin
            a_drv = (k % 8 < 4) ? '1 : rnd();
            b_drv = (k % 8 < 4) ? '1 : '0;
            a_in = rnd(); b_in = rnd(); cycle("R9");
        end

        // R8 both directions fully random at once
        for (int k = 0; k < 2000; k++) begin
            ab_le = ($urandom % 3) == 0; ba_le = ($urandom % 3) == 0;
            ab_clk = $urandom; ba_clk = $urandom;
            ab_oe = ($urandom % 4) != 0; ba_oe_n = ($urandom % 4) == 0;
            a_drv = ($urandom % 2) ? '1 : rnd();
            b_drv = ($urandom % 2) ? '1 : rnd();
            a_in = rnd(); b_in = rnd(); cycle("R8");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule